// File: doc/BRIEF.md
# Word-Addressed Data Memory with Range Fault

This block is the data store of a small processor model. It holds a parameterized number of words. One port serves both reads and writes, and each cycle carries at most one access. A read strobe returns the addressed word on the output within the same cycle, through combinational logic only. A write strobe stores the input word at the next rising clock edge. A synchronous active-high reset clears every word to zero.

The address input is wider than the implemented depth. Any access that names a word beyond the last one raises a fault flag in the same cycle. Such an access is not performed: a faulting write leaves the whole array as it was, and a faulting read drives zeros. Raising both strobes in one cycle is also treated as a fault, because only one access may happen at a time. When neither strobe is active, the block does nothing and reports no fault.

Top module: `dmem_top`

## Requirements
- R1: After a synchronous reset, every word from index 0 to DEPTH-1 reads as zero.
- R2: With the read strobe high, the write strobe low and the address below DEPTH, the output equals the stored word in the same cycle and the fault flag is 0.
- R3: With the write strobe high, the read strobe low and the address below DEPTH, the input word is stored at the rising edge. A read in a later cycle returns it. The fault flag is 0, and the output is 0 during the write cycle.
- R4: When either strobe is high and the address is DEPTH or greater, the fault flag is 1 in that same cycle.
- R5: A write with an address of DEPTH or greater changes no word. In particular, it does not change the word whose index equals the address modulo DEPTH.
- R6: A read with an address of DEPTH or greater drives all zeros on the output.
- R7: With both strobes high, the fault flag is 1, the output is zero and no word changes, whatever the address.
- R8: With both strobes low, the fault flag is 0, the output is zero and no word changes.
- R9: Reset takes priority over a write strobe in the same cycle: that word reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| mem_addr | input | ADDR_W | Word address of the access |
| wr_word | input | WORD_W | Word to store on a write |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe |
| rd_word | output | WORD_W | Read result, zero unless a valid read is under way |
| range_fault | output | 1 | High for an out-of-range access or for both strobes at once |

## Verification
The assertions expect the strobes and the address to be stable and free of X between clock edges, with reset held from time zero. They do not depend on any particular mix of strobes. The stimulus changes inputs only on the falling edge. It uses the full address width, so out-of-range addresses occur both just above the last word and near the top of the space. It also drives both-strobe and idle cycles on purpose, including one cycle with reset and a write strobe together.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Decoded kind of the access presented in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_FAULT = 2'd3
    } acc_kind_e;

    // One access per cycle; a conflict or an out-of-range address faults
    function automatic acc_kind_e classify(input logic rd, input logic wr,
                                           input logic in_range);
        acc_kind_e k;
        if (!rd && !wr)       k = ACC_IDLE;
        else if (rd && wr)    k = ACC_FAULT;
        else if (!in_range)   k = ACC_FAULT;
        else if (rd)          k = ACC_READ;
        else                  k = ACC_WRITE;
        return k;
    endfunction

    function automatic logic is_fault(input acc_kind_e k);
        return k == ACC_FAULT;
    endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              fault
);

    // One extra bit keeps the limit exact when DEPTH equals 2**ADDR_W
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic in_range;

    always_comb begin
        in_range = {1'b0, addr} < LIMIT;
        kind     = classify(rd, wr, in_range);
        idx      = addr[IDX_W-1:0];
        fault    = is_fault(kind);
    end

endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[idx] <= wdata;
        end
    end

    assign rdata = store[idx];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> store[$past(idx)] == $past(wdata));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> store[$past(idx)] == '0);

endmodule

// File: rtl/dmem_top.sv
module dmem_top
    import dmem_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic [WORD_W-1:0] rd_word,
    output logic              range_fault
);

    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] raw_word;
    logic              store_en;

    dmem_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_decode (
        .addr  (mem_addr),
        .rd    (rd_req),
        .wr    (wr_req),
        .kind  (kind),
        .idx   (idx),
        .fault (range_fault)
    );

    assign store_en = (kind == ACC_WRITE);

    dmem_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (store_en),
        .idx   (idx),
        .wdata (wr_word),
        .rdata (raw_word)
    );

    // Only a clean read drives data; all else shows zeros
    assign rd_word = (kind == ACC_READ) ? raw_word : '0;

    // R4
    oor_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_req || wr_req) && (int'(mem_addr) >= DEPTH)) |-> range_fault);

    // R7
    dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |-> (range_fault && rd_word == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_req && !wr_req) |-> (!range_fault && rd_word == '0));

    // R6
    zero_unless_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_req || range_fault) |-> rd_word == '0);

endmodule

// File: tb/sim_dmem_top.sv
module sim_dmem_top;

    localparam int DEPTH  = 1024;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [WORD_W-1:0] wr_word = '0;
    logic              rd_req = 1'b0;
    logic              wr_req = 1'b0;
    logic [WORD_W-1:0] rd_word;
    logic              range_fault;

    int checks = 0;
    int fails  = 0;
    logic [WORD_W-1:0] model [DEPTH];

    always #10 clk = ~clk;   // 50 MHz

    dmem_top #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .wr_word(wr_word),
        .rd_req(rd_req), .wr_req(wr_req), .rd_word(rd_word),
        .range_fault(range_fault)
    );

    task automatic check(input string tag, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One access: drive at the falling edge, check mid-low phase, let the edge act
    task automatic access(input string tag, input logic rd, input logic wr,
                          input int addr, input logic [WORD_W-1:0] data);
        logic inr, vrd, vwr, ferr;
        logic [WORD_W-1:0] edat;
        @(negedge clk);
        rd_req = rd; wr_req = wr; mem_addr = ADDR_W'(addr); wr_word = data;
        #5;
        inr  = addr < DEPTH;
        vrd  = rd && !wr && inr;
        vwr  = wr && !rd && inr;
        ferr = (rd && wr) || ((rd || wr) && !inr);
        edat = vrd ? model[addr] : '0;
        check(tag, "rd_word", rd_word, edat);
        check(tag, "range_fault", {{(WORD_W-1){1'b0}}, range_fault},
              {{(WORD_W-1){1'b0}}, ferr});
        if (vwr) model[addr] = data;
    endtask

    function automatic string auto_tag(input logic rd, input logic wr, input int addr);
        if (rd && wr)          return "R7";
        if (!rd && !wr)        return "R8";
        if (addr >= DEPTH)     return rd ? "R6" : "R5";
        return rd ? "R2" : "R3";
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: every word zero after reset
        for (int a = 0; a < DEPTH; a++) access("R1", 1'b1, 1'b0, a, '0);

        // R3 / R2: boundary words written then read
        access("R3", 1'b0, 1'b1, 0, 32'hA5A5_0001);
        access("R3", 1'b0, 1'b1, DEPTH - 1, 32'h5A5A_FFFF);
        access("R2", 1'b1, 1'b0, 0, '0);
        access("R2", 1'b1, 1'b0, DEPTH - 1, '0);

        // R4 / R6: reads just past the end and at the top of the space
        access("R4", 1'b1, 1'b0, DEPTH, '0);
        access("R6", 1'b1, 1'b0, (1 << ADDR_W) - 1, '0);

        // R5: out-of-range write must not alias onto index 5
        access("R3", 1'b0, 1'b1, 5, 32'h0000_0555);
        access("R5", 1'b0, 1'b1, DEPTH + 5, 32'hDEAD_BEEF);
        access("R5", 1'b1, 1'b0, 5, '0);

        // R7: both strobes, then confirm index 7 untouched
        access("R7", 1'b1, 1'b1, 7, 32'h1234_5678);
        access("R7", 1'b1, 1'b0, 7, '0);

        // R8: idle with an out-of-range address and live data
        access("R8", 1'b0, 1'b0, DEPTH + 6, 32'hFFFF_FFFF);
        access("R8", 1'b1, 1'b0, 0, '0);

        // Mixed traffic, tagged by access kind
        for (int n = 0; n < 3000; n++) begin
            int a;
            logic r, w;
            a = (n % 4 == 0) ? int'($urandom_range((1 << ADDR_W) - 1, 0))
                             : int'($urandom_range(DEPTH - 1, 0) % 64);
            r = 1'($urandom_range(1, 0));
            w = 1'($urandom_range(1, 0));
            access(auto_tag(r, w, a), r, w, a, $urandom());
        end

        // R9: reset together with a write strobe
        @(negedge clk);
        rst = 1'b1; wr_req = 1'b1; rd_req = 1'b0;
        mem_addr = ADDR_W'(9); wr_word = 32'hCAFE_0009;
        @(negedge clk);
        rst = 1'b0; wr_req = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        access("R9", 1'b1, 1'b0, 9, '0);
        access("R9", 1'b1, 1'b0, 0, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule